// File: doc/BRIEF.md
# Watchdog Supervisor with Reset Sequencer

This block watches over program execution. A 16-bit up counter advances on ticks from a prescaler. The prescaler divides the system clock by one of four ratios: two fine ratios and two coarse ratios. Software must pulse a service strobe before the counter passes its all-ones value. The strobe loads the counter's high byte from a reload value, clears its low byte and restarts the prescaler. If the counter wraps without service, the block runs an internal reset sequence of fixed length. During that sequence it pulls its reset output low. It can also pull a bidirectional reset line low, and it records that the watchdog caused the reset.

A software reset request starts the same sequence but leaves the watchdog flag untouched. The reset output stays low after a power-on reset or after any sequence. It is released only when software issues an end-of-initialization strobe while no sequence is running. The running count is offered on an output as a read-only value, and nothing can write it directly. All pins are plain level or single-cycle strobe signals sampled on the clock edge. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_supervisor`

## Requirements
- R1: The counter advances by one every 2, 4, 128 or 256 clock cycles when {ps_coarse, ps_double} is 2'b00, 2'b01, 2'b10 or 2'b11 respectively.
- R2: After power-on reset `wdt_count` is 0, and outside a sequence it changes only by +1 per prescaler tick, by a service load, or to 0.
- R3: A service strobe outside a sequence sets `wdt_count` to {svc_reload, 8'h00} on the next edge and restarts the prescaler. The next increment therefore follows exactly one full division period later.
- R4: A tick while `wdt_count` is 16'hFFFF starts an internal sequence. `int_rst` then stays high for exactly SEQ_LEN (1024) cycles while `wdt_count` reads 0, and service strobes during it have no effect.
- R5: `rst_out_n` is low after power-on reset and from the start of every sequence. It rises on the edge after an `einit` strobe that is sampled while `int_rst` is low; `einit` during a sequence is ignored.
- R6: `rstin_drv_n` is low exactly while `int_rst` is high and `bidir_en` is 1, and high otherwise.
- R7: A `sw_rst_req` strobe outside a sequence starts the same sequence without setting `wdt_flag`.
- R8: `wdt_flag` is set when an overflow starts a sequence and keeps its value through that sequence. Only power-on reset or a `flag_clr` strobe outside a sequence clears it.
- R9: In one cycle a software reset request wins over a service strobe, and a service strobe wins over a pending tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ps_coarse | input | 1 | Prescaler range select (0 fine, 1 coarse) |
| ps_double | input | 1 | Prescaler doubling select |
| svc | input | 1 | Service strobe |
| svc_reload | input | 8 | Reload value for the counter high byte |
| sw_rst_req | input | 1 | Software reset request strobe |
| einit | input | 1 | End-of-initialization strobe, releases reset output |
| flag_clr | input | 1 | Software clear of the watchdog flag |
| bidir_en | input | 1 | Enables driving of the bidirectional reset line |
| wdt_count | output | 16 | Current counter value (read-only) |
| int_rst | output | 1 | Internal reset sequence active |
| rst_out_n | output | 1 | Reset output, active low |
| rstin_drv_n | output | 1 | Drive for the bidirectional reset line, active low |
| wdt_flag | output | 1 | Watchdog caused the last sequence |

## Verification
A wrong prescaler phase or limit shows on `wdt_count` within one division period. A missed or doubled increment then stays visible in every later count. A sequence counter that ends early or late moves the falling edge of `int_rst`, and the error is seen in the cycle where that edge should have come. A corrupted reset-output or flag register shows on `rst_out_n` or `wdt_flag` at the next strobe that should have changed it. The bench compares every output on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PS_FINE_A   = 2'b00,
    PS_FINE_B   = 2'b01,
    PS_COARSE_A = 2'b10,
    PS_COARSE_B = 2'b11
  } ps_sel_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int pick_div(input int idx, input int d0, input int d1,
                                  input int d2, input int d3);
    case (idx)
      0:       return d0;
      1:       return d1;
      2:       return d2;
      default: return d3;
    endcase
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int DIV0  = 2,
  parameter int DIV1  = 4,
  parameter int DIV2  = 128,
  parameter int DIV3  = 256,
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ps_sel_e    sel,
  input  logic       restart,
  output logic       tick
);

  logic [PRE_W-1:0] lim [4];
  logic [PRE_W-1:0] pre_q;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int DV = pick_div(g, DIV0, DIV1, DIV2, DIV3);
    assign lim[g] = PRE_W'(DV - 1);
  end

  // >= keeps a mid-count switch to a smaller ratio from running past the limit
  assign tick = (pre_q >= lim[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16,
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             load,
  input  logic [RLD_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam int LOW_W = CNT_W - RLD_W;

  logic [CNT_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick & ~hold & ~load & (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= {load_val, {LOW_W{1'b0}}};
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
  import wdt_pkg::*;
#(
  parameter int SEQ_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wd_cause,
  input  logic einit,
  input  logic flag_clr,
  input  logic bidir_en,
  output logic active,
  output logic rst_out_n,
  output logic rstin_drv_n,
  output logic wd_flag
);

  localparam int SEQ_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [SEQ_W-1:0] LAST = SEQ_W'(SEQ_LEN - 1);

  seq_state_e       state_q;
  logic [SEQ_W-1:0] seq_cnt_q;
  logic             out_low_q;
  logic             flag_q;

  assign active      = (state_q == SEQ_RUN);
  assign rst_out_n   = ~out_low_q;
  assign rstin_drv_n = ~(active & bidir_en);
  assign wd_flag     = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      seq_cnt_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q   <= SEQ_RUN;
            seq_cnt_q <= '0;
          end
        end
        default: begin
          if (seq_cnt_q == LAST) begin
            state_q   <= SEQ_IDLE;
            seq_cnt_q <= '0;
          end else begin
            seq_cnt_q <= seq_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_low_q <= 1'b1;
    end else if (start) begin
      out_low_q <= 1'b1;
    end else if (einit && !active) begin
      out_low_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wd_cause) begin
      flag_q <= 1'b1;
    end else if (flag_clr && !active) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RLD_W   = 8,
  parameter int SEQ_LEN = 1024,
  parameter int DIV0    = 2,
  parameter int DIV1    = 4,
  parameter int DIV2    = 128,
  parameter int DIV3    = 256
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ps_coarse,
  input  logic             ps_double,
  input  logic             svc,
  input  logic [RLD_W-1:0] svc_reload,
  input  logic             sw_rst_req,
  input  logic             einit,
  input  logic             flag_clr,
  input  logic             bidir_en,
  output logic [CNT_W-1:0] wdt_count,
  output logic             int_rst,
  output logic             rst_out_n,
  output logic             rstin_drv_n,
  output logic             wdt_flag
);

  localparam int PRE_W = $clog2(DIV3);

  ps_sel_e sel;
  logic    block;
  logic    svc_acc;
  logic    tick;
  logic    wrap;
  logic    seq_start;

  assign sel       = ps_sel_e'({ps_coarse, ps_double});
  assign block     = int_rst | sw_rst_req;
  assign svc_acc   = svc & ~block;
  assign seq_start = ~int_rst & (sw_rst_req | wrap);

  wdt_prescaler #(
    .DIV0 (DIV0),
    .DIV1 (DIV1),
    .DIV2 (DIV2),
    .DIV3 (DIV3),
    .PRE_W(PRE_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (por_n),
    .sel    (sel),
    .restart(block | svc_acc),
    .tick   (tick)
  );

  wdt_counter #(
    .CNT_W(CNT_W),
    .RLD_W(RLD_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (por_n),
    .hold    (block),
    .load    (svc_acc),
    .load_val(svc_reload),
    .tick    (tick),
    .cnt     (wdt_count),
    .wrap    (wrap)
  );

  wdt_reset_seq #(
    .SEQ_LEN(SEQ_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (por_n),
    .start      (seq_start),
    .wd_cause   (wrap),
    .einit      (einit),
    .flag_clr   (flag_clr),
    .bidir_en   (bidir_en),
    .active     (int_rst),
    .rst_out_n  (rst_out_n),
    .rstin_drv_n(rstin_drv_n),
    .wd_flag    (wdt_flag)
  );

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int CNT_W   = 16,
  parameter int RLD_W   = 8,
  parameter int SEQ_LEN = 1024
) (
  input logic             clk,
  input logic             por_n,
  input logic             svc,
  input logic             flag_clr,
  input logic             bidir_en,
  input logic [CNT_W-1:0] wdt_count,
  input logic             int_rst,
  input logic             rst_out_n,
  input logic             rstin_drv_n,
  input logic             wdt_flag
);

  localparam int LOW_W = CNT_W - RLD_W;
  localparam int RUN_W = $clog2(SEQ_LEN + 1) + 1;

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!por_n)       run_len <= '0;
    else if (int_rst) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  // R2: count moves only by one step, a reload, or to zero
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_count != $past(wdt_count)) |->
      ((wdt_count == CNT_W'($past(wdt_count) + 1'b1)) || (wdt_count[LOW_W-1:0] == '0)));

  // R4: counter reads zero throughout a sequence
  p_seq_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> (wdt_count == '0));

  // R4: sequence lasts exactly SEQ_LEN cycles
  p_seq_len_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(int_rst) |-> (run_len == RUN_W'(SEQ_LEN)));

  // R4: a service strobe during a sequence leaves the count at zero
  p_svc_ignored_r4: assert property (@(posedge clk) disable iff (!por_n)
    (int_rst && svc) |=> (wdt_count == '0));

  // R5: reset output is low whenever a sequence runs
  p_rstout_low_r5: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> !rst_out_n);

  // R6: the bidirectional line is driven only during a sequence
  p_rstin_idle_r6: assert property (@(posedge clk) disable iff (!por_n)
    !int_rst |-> rstin_drv_n);

  // R6: with the line enabled it follows the sequence
  p_rstin_on_r6: assert property (@(posedge clk) disable iff (!por_n)
    (int_rst && bidir_en) |-> !rstin_drv_n);

  // R8: the flag only falls after a clear strobe outside a sequence
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wdt_flag) |-> ($past(flag_clr) && !$past(int_rst)));

endmodule

bind wdt_supervisor wdt_supervisor_chk #(
  .CNT_W  (CNT_W),
  .RLD_W  (RLD_W),
  .SEQ_LEN(SEQ_LEN)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .svc        (svc),
  .flag_clr   (flag_clr),
  .bidir_en   (bidir_en),
  .wdt_count  (wdt_count),
  .int_rst    (int_rst),
  .rst_out_n  (rst_out_n),
  .rstin_drv_n(rstin_drv_n),
  .wdt_flag   (wdt_flag)
);

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;

  localparam int SEQ = 1024;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        ps_coarse = 1'b0;
  logic        ps_double = 1'b0;
  logic        svc = 1'b0;
  logic [7:0]  svc_reload = 8'h00;
  logic        sw_rst_req = 1'b0;
  logic        einit = 1'b0;
  logic        flag_clr = 1'b0;
  logic        bidir_en = 1'b0;
  logic [15:0] wdt_count;
  logic        int_rst;
  logic        rst_out_n;
  logic        rstin_drv_n;
  logic        wdt_flag;

  always #10 clk = ~clk;

  wdt_supervisor dut (
    .clk        (clk),
    .por_n      (por_n),
    .ps_coarse  (ps_coarse),
    .ps_double  (ps_double),
    .svc        (svc),
    .svc_reload (svc_reload),
    .sw_rst_req (sw_rst_req),
    .einit      (einit),
    .flag_clr   (flag_clr),
    .bidir_en   (bidir_en),
    .wdt_count  (wdt_count),
    .int_rst    (int_rst),
    .rst_out_n  (rst_out_n),
    .rstin_drv_n(rstin_drv_n),
    .wdt_flag   (wdt_flag)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R2";

  // behavioural reference
  int m_pre = 0, m_cnt = 0, m_seqc = 0;
  bit m_seq = 0, m_low = 1, m_flag = 0;

  function automatic int div_now();
    case ({ps_coarse, ps_double})
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 128;
      default: return 256;
    endcase
  endfunction

  always @(posedge clk) begin
    bit start;
    bit tk;
    start = 0;
    if (!por_n) begin
      m_pre = 0; m_cnt = 0; m_seqc = 0; m_seq = 0; m_low = 1; m_flag = 0;
    end else if (m_seq) begin
      m_cnt = 0; m_pre = 0;
      if (m_seqc == SEQ - 1) begin m_seq = 0; m_seqc = 0; end
      else m_seqc++;
    end else begin
      tk = (m_pre >= div_now() - 1);
      if (flag_clr) m_flag = 0;
      if (sw_rst_req) start = 1;
      else if (svc) begin m_cnt = int'(svc_reload) * 256; m_pre = 0; end
      else if (tk) begin
        m_pre = 0;
        if (m_cnt == 65535) begin start = 1; m_flag = 1; end
        else m_cnt++;
      end else m_pre++;
      if (start) begin m_seq = 1; m_seqc = 0; m_cnt = 0; m_pre = 0; m_low = 1; end
      else if (einit) m_low = 0;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(cur_req, "wdt_count", wdt_count, m_cnt);
      chk("R4", "int_rst", int_rst, m_seq);
      chk("R5", "rst_out_n", rst_out_n, !m_low);
      chk("R6", "rstin_drv_n", rstin_drv_n, !(m_seq && bidir_en));
      chk("R8", "wdt_flag", wdt_flag, m_flag);
    end
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_svc(input logic [7:0] v);
    svc_reload = v; svc = 1'b1;
    @(negedge clk);
    svc = 1'b0;
  endtask

  task automatic pulse_einit();
    einit = 1'b1; @(negedge clk); einit = 1'b0;
  endtask

  task automatic wait_seq();
    for (int i = 0; i < 80000 && !int_rst; i++) @(negedge clk);
  endtask

  task automatic ratio_test(input logic c, input logic d, input int dv, input string req);
    ps_coarse = c; ps_double = d;
    cur_req = req;
    pulse_svc(8'h10);
    chk("R3", "count after service", wdt_count, 16'h1000);
    wait_cyc(3 * dv - 1);
    chk(req, "count one cycle before third step", wdt_count, 16'h1002);
    wait_cyc(1);
    chk(req, "count at third step", wdt_count, 16'h1003);
  endtask

  initial begin
    @(negedge clk);
    wait_cyc(4);
    cmp_on = 1'b1;
    // R2 R5 R8: reset state
    chk("R2", "count at reset", wdt_count, 0);
    chk("R5", "rst_out_n at reset", rst_out_n, 0);
    chk("R8", "flag at reset", wdt_flag, 0);
    por_n = 1'b1;
    wait_cyc(3);
    pulse_einit();
    chk("R5", "rst_out_n after einit", rst_out_n, 1);

    // R1 R3: the four ratios
    ratio_test(1'b0, 1'b0, 2,   "R1");
    ratio_test(1'b0, 1'b1, 4,   "R1");
    ratio_test(1'b1, 1'b0, 128, "R1");
    ratio_test(1'b1, 1'b1, 256, "R1");
    // R3: restart mid-period pushes the next step one full period out
    wait_cyc(100);
    cur_req = "R3";
    pulse_svc(8'h20);
    wait_cyc(255);
    chk("R3", "no step before full period", wdt_count, 16'h2000);
    wait_cyc(1);
    chk("R3", "step after full period", wdt_count, 16'h2001);

    // R4 R6 R8: overflow with bidirectional line enabled
    ps_coarse = 1'b0; ps_double = 1'b0; bidir_en = 1'b1;
    cur_req = "R4";
    pulse_svc(8'hFF);
    wait_seq();
    chk("R4", "sequence started", int_rst, 1);
    chk("R8", "flag set by overflow", wdt_flag, 1);
    chk("R6", "line driven", rstin_drv_n, 0);
    chk("R5", "rst_out_n low in sequence", rst_out_n, 0);
    wait_cyc(10);
    pulse_svc(8'h55);
    chk("R4", "service ignored in sequence", wdt_count, 0);
    pulse_einit();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    wait_cyc(SEQ - 14);
    chk("R4", "still active at last cycle", int_rst, 1);
    wait_cyc(1);
    chk("R4", "released after SEQ_LEN", int_rst, 0);
    chk("R8", "flag survives sequence", wdt_flag, 1);
    chk("R5", "einit in sequence ignored", rst_out_n, 0);
    pulse_einit();
    chk("R5", "released by einit", rst_out_n, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R8", "flag cleared by write", wdt_flag, 0);

    // R7 R6: software reset with line disabled
    bidir_en = 1'b0;
    cur_req = "R7";
    pulse_svc(8'h30);
    sw_rst_req = 1'b1; @(negedge clk); sw_rst_req = 1'b0;
    chk("R7", "software sequence", int_rst, 1);
    chk("R7", "flag not set", wdt_flag, 0);
    chk("R6", "line idle when disabled", rstin_drv_n, 1);
    wait_cyc(SEQ);
    chk("R7", "software sequence ended", int_rst, 0);
    pulse_einit();

    // R9: software reset and service together
    cur_req = "R9";
    svc_reload = 8'h44; svc = 1'b1; sw_rst_req = 1'b1;
    @(negedge clk);
    svc = 1'b0; sw_rst_req = 1'b0;
    chk("R9", "reset wins over service", int_rst, 1);
    chk("R9", "count zero", wdt_count, 0);
    wait_cyc(SEQ);
    pulse_einit();
    // R9: service on a tick cycle (div 2 makes every other cycle a tick)
    pulse_svc(8'h50);
    wait_cyc(1);
    pulse_svc(8'h60);
    chk("R9", "service wins over tick", wdt_count, 16'h6000);

    // R1 R4: coarse overflow
    ps_coarse = 1'b1; ps_double = 1'b0; bidir_en = 1'b1;
    cur_req = "R1";
    pulse_svc(8'hFF);
    wait_seq();
    chk("R4", "coarse overflow", int_rst, 1);
    chk("R8", "flag after coarse overflow", wdt_flag, 1);
    wait_cyc(20);

    // R8: power-on reset clears the flag
    por_n = 1'b0;
    wait_cyc(2);
    por_n = 1'b1;
    wait_cyc(1);
    chk("R8", "flag cleared by power-on", wdt_flag, 0);
    chk("R2", "count after power-on", wdt_count, 0);
    wait_cyc(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule